// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

This block is a full-duplex asynchronous serial port that sends and receives frames at the same time. It has three frame formats. The 8-bit format carries one byte. The two 9-bit formats add a ninth data bit, which multiprocessor links use to tell address frames from data frames. Even parity is optional. When parity is on, the parity bit takes the slot of the last data bit of the frame, so the frame length never changes. All bit timing comes from an external tick that runs at sixteen times the bit rate. The receiver samples each bit at its centre.

Software-side logic writes a byte (and a ninth bit) with a single-cycle strobe. Each direction reports completion through a flag that stays set until it is cleared, and through a one-cycle interrupt-pending pulse. One of the 9-bit formats raises that pulse only for frames whose ninth bit is 1. A receiving node can therefore ignore data frames and react only to address frames. Dropping the receive enable cancels a reception that is under way.

Top module: `asp_top`

## Requirements
- R1: After reset, `txd` is 1, and `tx_flag`, `rx_flag`, `tx_int`, `rx_int`, `rx_err`, `rx_bit8` and `rx_data` are all 0.
- R2: Modes 1 and 0 (`mode` = 2'd1 or 2'd0) send a 10-slot frame: a start bit of 0, then eight data bits least significant bit first, then a stop bit of 1. Each slot lasts 16 ticks of `os_tick`, and `txd` rests at 1 between frames.
- R3: Parity is even. In mode 1 with `par_en` = 1, the slot of data bit 7 carries the XOR of `tx_data[6:0]`. In modes 2 and 3 with `par_en` = 1, the ninth slot carries the XOR of `tx_data[7:0]`, and `tx_bit8` is ignored.
- R4: Modes 2 and 3 (`mode` = 2'd2 / 2'd3) send a start bit, then `tx_data[0]` to `tx_data[7]`, then `tx_bit8`, then a stop bit: 11 slots in all.
- R5: `tx_flag` rises, and `tx_int` pulses for one cycle at the same time, exactly (1+N)×16 ticks after the start bit begins, where N is the number of data slots (8 or 9). This is the moment the stop bit begins. In mode 2, `tx_int` stays low when the ninth slot sent was 0.
- R6: A `tx_wr` that arrives during a frame is held. Its start bit begins on the tick that ends the current frame's 16-tick stop bit, so the two start bits are (2+N)×16 ticks apart.
- R7: A 1-to-0 transition on `rxd` while `rx_en` = 1 starts a reception. On completion, `rx_data` holds the eight received data slots. In modes 2 and 3, `rx_bit8` holds the ninth slot; in mode 1 it reads 0. In mode 1 with parity, `rx_data[7]` holds the received parity slot.
- R8: `rx_int` pulses for one cycle, and `rx_flag` rises in the following cycle. In mode 2 the pulse is left out when the received ninth slot is 0, but `rx_flag` is still set.
- R9: `rx_err` is set when a frame completes with an even-parity mismatch (only when `par_en` = 1) or with a stop bit sampled as 0. It stays set through later frames until `clr_rx`.
- R10: A low pulse on `rxd` that has ended before half a bit time is rejected as a glitch. No flag or pulse results, and the next proper frame is received correctly.
- R11: While `rx_en` = 0, falling edges start nothing. Clearing `rx_en` during a frame abandons that frame, so no flag or pulse is produced for it.
- R12: `tx_flag` and `rx_flag` stay at 1 until a one-cycle `clr_tx` / `clr_rx`, which returns them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| mode | input | 2 | Frame format: 0/1 eight-bit, 2 nine-bit gated, 3 nine-bit |
| par_en | input | 1 | Even parity in the last data slot |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 8 | Transmit byte |
| tx_bit8 | input | 1 | Transmit ninth bit |
| clr_tx | input | 1 | Clears `tx_flag` |
| clr_rx | input | 1 | Clears `rx_flag` and `rx_err` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 8 | Received byte |
| rx_bit8 | output | 1 | Received ninth bit |
| rx_err | output | 1 | Sticky parity/stop error |
| tx_flag | output | 1 | Transmit done flag |
| rx_flag | output | 1 | Receive done flag |
| tx_int | output | 1 | Transmit interrupt-pending pulse |
| rx_int | output | 1 | Receive interrupt-pending pulse |

## Verification
The hardest cases to reach from the ports are those in which the receiver must leave a frame early. This happens in two ways: a start edge that the mid-bit check rejects, and a frame that is abandoned halfway when `rx_en` drops. The bench reaches both by driving `rxd` with cycle-exact timing. It drives a short low pulse well under half a bit long. In a parallel thread, it removes the enable 60 cycles into a live frame and holds it low until the line has gone quiet, then sends a clean frame to show the receiver has recovered. The held write is reached by issuing a second write while the first frame is still being shifted out, then measuring the distance between the two start bits.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP
  } txst_e;

  typedef enum logic [2:0] {
    R_IDLE,
    R_START,
    R_DATA,
    R_STOP,
    R_DONE
  } rxst_e;

  // Nine-slot formats are modes 2 and 3.
  function automatic logic is_nine(input logic [1:0] m);
    return m[1];
  endfunction

  // Mode 2 lets an interrupt through only for a ninth bit of 1.
  function automatic logic irq_gate(input logic [1:0] m, input logic ninth);
    return (m != 2'd2) || ninth;
  endfunction

endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) r_q[0] <= RST_VAL;
        else         r_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) r_q[i] <= RST_VAL;
        else         r_q[i] <= r_q[i-1];
      end
    end
  end

  assign q = r_q[STAGES-1];
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick,
  input  logic [1:0]    mode,
  input  logic          par_en,
  input  logic          wr,
  input  logic [DW-1:0] data,
  input  logic          bit8,
  input  logic          clr,
  output logic          txd,
  output logic          flag,
  output logic          irq
);
  localparam int CW = $clog2(OVS);
  localparam int FW = DW + 1;
  localparam int BW = $clog2(FW + 1);

  txst_e           st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [BW-1:0]   bidx_q, bidx_n, last_q, last_n;
  logic [FW-1:0]   sh_q, sh_n, frame;
  logic            gate_q, gate_n;
  logic            txd_q, txd_n, flag_q, flag_n, irq_q, irq_n;
  logic            pv_q, pv_n, pb_q, pb_n;
  logic [DW-1:0]   pd_q, pd_n;
  logic            load, bit_end;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bidx_n = bidx_q;
    last_n = last_q;
    sh_n   = sh_q;
    gate_n = gate_q;
    txd_n  = txd_q;
    irq_n  = 1'b0;
    flag_n = flag_q & ~clr;
    pv_n   = pv_q;
    pd_n   = pd_q;
    pb_n   = pb_q;
    load   = 1'b0;
    bit_end = tick && (cnt_q == CW'(OVS - 1));

    // Frame image of the held write, parity folded into the last slot.
    frame = {pb_q, pd_q};
    if (is_nine(mode)) begin
      if (par_en) frame[DW] = ^pd_q;
    end else begin
      frame[DW] = 1'b0;
      if (par_en) frame[DW-1] = ^pd_q[DW-2:0];
    end

    case (st_q)
      S_IDLE: load = pv_q;
      S_START: begin
        if (tick) cnt_n = bit_end ? '0 : cnt_q + 1'b1;
        if (bit_end) begin
          st_n   = S_DATA;
          txd_n  = sh_q[0];
          sh_n   = {1'b0, sh_q[FW-1:1]};
          bidx_n = '0;
        end
      end
      S_DATA: begin
        if (tick) cnt_n = bit_end ? '0 : cnt_q + 1'b1;
        if (bit_end) begin
          if (bidx_q == last_q) begin
            st_n   = S_STOP;
            txd_n  = 1'b1;
            flag_n = 1'b1;
            irq_n  = gate_q;
          end else begin
            txd_n  = sh_q[0];
            sh_n   = {1'b0, sh_q[FW-1:1]};
            bidx_n = bidx_q + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (tick) cnt_n = bit_end ? '0 : cnt_q + 1'b1;
        if (bit_end) begin
          load = pv_q;
          if (!pv_q) st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase

    if (load) begin
      st_n   = S_START;
      txd_n  = 1'b0;
      cnt_n  = '0;
      sh_n   = frame;
      last_n = is_nine(mode) ? BW'(DW) : BW'(DW - 1);
      gate_n = irq_gate(mode, frame[DW]);
      pv_n   = 1'b0;
    end

    if (wr) begin
      pv_n = 1'b1;
      pd_n = data;
      pb_n = bit8;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      last_q <= '0;
      sh_q   <= '0;
      gate_q <= 1'b0;
      txd_q  <= 1'b1;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      pv_q   <= 1'b0;
      pd_q   <= '0;
      pb_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bidx_q <= bidx_n;
      last_q <= last_n;
      sh_q   <= sh_n;
      gate_q <= gate_n;
      txd_q  <= txd_n;
      flag_q <= flag_n;
      irq_q  <= irq_n;
      pv_q   <= pv_n;
      pd_q   <= pd_n;
      pb_q   <= pb_n;
    end
  end

  assign txd  = txd_q;
  assign flag = flag_q;
  assign irq  = irq_q;

  // R2: line rests high between frames and is low through the start slot.
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_IDLE) |-> txd_q);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_START) |-> !txd_q);
  // R5: the pulse only comes with the flag, at the start of the stop slot.
  p_irq_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_q |-> (flag_q && st_q == S_STOP && txd_q));
  // R6: a write during a frame is kept.
  p_wr_kept_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr && st_q != S_IDLE) |=> pv_q);
  // R12: flag holds until cleared.
  p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick,
  input  logic [1:0]    mode,
  input  logic          par_en,
  input  logic          en,
  input  logic          line,
  input  logic          clr,
  output logic [DW-1:0] data,
  output logic          bit8,
  output logic          err,
  output logic          flag,
  output logic          irq
);
  localparam int CW   = $clog2(OVS);
  localparam int FW   = DW + 1;
  localparam int BW   = $clog2(FW + 1);
  localparam int HALF = OVS / 2 - 1;

  rxst_e         st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [BW-1:0] bidx_q, bidx_n, last;
  logic [FW-1:0] sh_q, sh_n, word;
  logic          prev_q, sbad_q, sbad_n;
  logic [DW-1:0] data_q, data_n;
  logic          b8_q, b8_n, err_q, err_n, flag_q, flag_n, irq_q, irq_n;
  logic          bit_end, half_end, perr, busy;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bidx_n = bidx_q;
    sh_n   = sh_q;
    sbad_n = sbad_q;
    data_n = data_q;
    b8_n   = b8_q;
    err_n  = err_q & ~clr;
    flag_n = flag_q & ~clr;
    irq_n  = 1'b0;

    last     = is_nine(mode) ? BW'(DW) : BW'(DW - 1);
    bit_end  = tick && (cnt_q == CW'(OVS - 1));
    half_end = tick && (cnt_q == CW'(HALF));
    word     = is_nine(mode) ? sh_q : {1'b0, sh_q[FW-1:1]};
    perr     = par_en && (^word);
    busy     = (st_q == R_START) || (st_q == R_DATA) || (st_q == R_STOP);

    case (st_q)
      R_IDLE: begin
        cnt_n = '0;
        if (en && prev_q && !line) st_n = R_START;
      end
      R_START: begin
        if (tick) cnt_n = cnt_q + 1'b1;
        if (half_end) begin
          if (line) begin
            st_n = R_IDLE;
          end else begin
            st_n   = R_DATA;
            cnt_n  = '0;
            bidx_n = '0;
          end
        end
      end
      R_DATA: begin
        if (tick) cnt_n = bit_end ? '0 : cnt_q + 1'b1;
        if (bit_end) begin
          sh_n = {line, sh_q[FW-1:1]};
          if (bidx_q == last) st_n = R_STOP;
          else                bidx_n = bidx_q + 1'b1;
        end
      end
      R_STOP: begin
        if (tick) cnt_n = bit_end ? '0 : cnt_q + 1'b1;
        if (bit_end) begin
          sbad_n = !line;
          irq_n  = irq_gate(mode, word[DW]);
          st_n   = R_DONE;
        end
      end
      R_DONE: begin
        st_n   = R_IDLE;
        flag_n = 1'b1;
        data_n = word[DW-1:0];
        b8_n   = word[DW];
        err_n  = err_n | perr | sbad_q;
      end
      default: st_n = R_IDLE;
    endcase

    if (!en && busy) begin
      st_n  = R_IDLE;
      irq_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= R_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      sbad_q <= 1'b0;
      data_q <= '0;
      b8_q   <= 1'b0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bidx_q <= bidx_n;
      sh_q   <= sh_n;
      prev_q <= line;
      sbad_q <= sbad_n;
      data_q <= data_n;
      b8_q   <= b8_n;
      err_q  <= err_n;
      flag_q <= flag_n;
      irq_q  <= irq_n;
    end
  end

  assign data = data_q;
  assign bit8 = b8_q;
  assign err  = err_q;
  assign flag = flag_q;
  assign irq  = irq_q;

  // R8: the pulse is followed by the flag one cycle later.
  p_irq_then_flag_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_q |=> flag_q);
  // R11: a live frame is dropped when receive is disabled.
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && (st_q == R_START || st_q == R_DATA || st_q == R_STOP)) |=> (st_q == R_IDLE));
  // R11: no frame starts while disabled.
  p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && st_q == R_IDLE) |=> (st_q == R_IDLE));
  // R12 / R9: flag and error hold until cleared.
  p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !clr) |=> flag_q);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_q && !clr) |=> err_q);
endmodule

// File: rtl/asp_top.sv
module asp_top #(
  parameter int OVS    = 16,
  parameter int DW     = 8,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic [1:0]    mode,
  input  logic          par_en,
  input  logic          rx_en,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit8,
  input  logic          clr_tx,
  input  logic          clr_rx,
  input  logic          rxd,
  output logic          txd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit8,
  output logic          rx_err,
  output logic          tx_flag,
  output logic          rx_flag,
  output logic          tx_int,
  output logic          rx_int
);
  logic rst_sn;
  logic rxd_s;

  // Reset asserts at once and is released on a clock edge.
  asp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_ni(rst_n),
    .d     (1'b1),
    .q     (rst_sn)
  );

  asp_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_rxd_sync (
    .clk   (clk),
    .rst_ni(rst_sn),
    .d     (rxd),
    .q     (rxd_s)
  );

  asp_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk   (clk),
    .rst_ni(rst_sn),
    .tick  (os_tick),
    .mode  (mode),
    .par_en(par_en),
    .wr    (tx_wr),
    .data  (tx_data),
    .bit8  (tx_bit8),
    .clr   (clr_tx),
    .txd   (txd),
    .flag  (tx_flag),
    .irq   (tx_int)
  );

  asp_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk   (clk),
    .rst_ni(rst_sn),
    .tick  (os_tick),
    .mode  (mode),
    .par_en(par_en),
    .en    (rx_en),
    .line  (rxd_s),
    .clr   (clr_rx),
    .data  (rx_data),
    .bit8  (rx_bit8),
    .err   (rx_err),
    .flag  (rx_flag),
    .irq   (rx_int)
  );

  // R5: transmit pulse never appears without the flag.
  p_txint_flag_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_int |-> tx_flag);
  // R1: nothing pending in the first cycle out of reset.
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sn) |-> (!tx_int && !rx_int && txd));
endmodule

// File: tb/asp_top_tb.sv
module asp_top_tb;
  logic       clk = 1'b0;
  logic       rst_n, os_tick, par_en, rx_en, tx_wr, tx_bit8, clr_tx, clr_rx, rxd;
  logic [1:0] mode;
  logic [7:0] tx_data;
  logic       txd, rx_bit8, rx_err, tx_flag, rx_flag, tx_int, rx_int;
  logic [7:0] rx_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  asp_top u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode(mode), .par_en(par_en),
    .rx_en(rx_en), .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit8(tx_bit8),
    .clr_tx(clr_tx), .clr_rx(clr_rx), .rxd(rxd), .txd(txd), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .rx_err(rx_err), .tx_flag(tx_flag), .rx_flag(rx_flag),
    .tx_int(tx_int), .rx_int(rx_int)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_tx(input logic [7:0] d, input logic b8);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = d; tx_bit8 = b8;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic tx_capture(input int nb, output logic [8:0] bits, output logic stopv,
                            output int dly, output logic irq, output int c0);
    int n = 0;
    bits = '0; dly = -1; irq = 1'b0; stopv = 1'b0;
    @(negedge clk);
    while (txd !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    c0 = cyc;
    clr_tx = 1'b1;
    @(negedge clk);
    clr_tx = 1'b0;
    repeat (7) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      bits[i] = txd;
    end
    n = 0;
    while (tx_flag !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    dly = cyc - c0;
    irq = tx_int;
    repeat (8) @(negedge clk);
    stopv = txd;
  endtask

  task automatic rx_send(input int nb, input logic [8:0] bits, input logic stopv,
                         input bit doclr, output int icyc, output int fcyc);
    icyc = -1; fcyc = -1;
    for (int k = 0; k < 16 * (nb + 2) + 12; k++) begin
      int slot;
      @(negedge clk);
      clr_rx = doclr && (k == 0);
      if (k > 0) begin
        if (rx_int === 1'b1 && icyc < 0) icyc = cyc;
        if (rx_flag === 1'b1 && fcyc < 0) fcyc = cyc;
      end
      slot = k / 16;
      if (slot == 0)           rxd = 1'b0;
      else if (slot <= nb)     rxd = bits[slot-1];
      else if (slot == nb + 1) rxd = stopv;
      else                     rxd = 1'b1;
    end
    clr_rx = 1'b0;
    rxd = 1'b1;
  endtask

  task automatic pulse_clr_rx;
    @(negedge clk); clr_rx = 1'b1;
    @(negedge clk); clr_rx = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "txd", txd, 1);
    chk("R1", "flags", {tx_flag, rx_flag}, 0);
    chk("R1", "ints", {tx_int, rx_int}, 0);
    chk("R1", "rx_err/bit8/data", {rx_err, rx_bit8, rx_data}, 0);
  endtask

  task automatic t_tx_mode1;
    logic [8:0] b; logic s, irq; int d, c0;
    mode = 2'd1; par_en = 1'b0;
    write_tx(8'hA5, 1'b0);
    tx_capture(8, b, s, d, irq, c0);
    chk("R2", "mode1 data A5", b[7:0], 8'hA5);
    chk("R2", "mode1 stop", s, 1);
    chk("R5", "mode1 flag delay", d, 144);
    chk("R5", "mode1 tx_int with flag", irq, 1);
    mode = 2'd0;
    write_tx(8'h3C, 1'b0);
    tx_capture(8, b, s, d, irq, c0);
    chk("R2", "mode0 data 3C", b[7:0], 8'h3C);
    chk("R2", "mode0 delay", d, 144);
    mode = 2'd1;
  endtask

  task automatic t_tx_parity;
    logic [8:0] b; logic s, irq; int d, c0;
    mode = 2'd1; par_en = 1'b1;
    write_tx(8'h13, 1'b0);
    tx_capture(8, b, s, d, irq, c0);
    chk("R3", "mode1 parity slot", b[7:0], 8'h93);
    mode = 2'd3;
    write_tx(8'h07, 1'b0);
    tx_capture(9, b, s, d, irq, c0);
    chk("R3", "nine-bit parity slot", b, 9'h107);
    par_en = 1'b0;
  endtask

  task automatic t_tx_nine;
    logic [8:0] b; logic s, irq; int d, c0;
    mode = 2'd3; par_en = 1'b0;
    write_tx(8'h5A, 1'b1);
    tx_capture(9, b, s, d, irq, c0);
    chk("R4", "mode3 frame", b, 9'h15A);
    chk("R4", "mode3 stop", s, 1);
    chk("R5", "mode3 flag delay", d, 160);
    chk("R5", "mode3 tx_int", irq, 1);
  endtask

  task automatic t_tx_gate;
    logic [8:0] b; logic s, irq; int d, c0;
    mode = 2'd2; par_en = 1'b0;
    write_tx(8'h11, 1'b0);
    tx_capture(9, b, s, d, irq, c0);
    chk("R5", "mode2 flag delay ninth 0", d, 160);
    chk("R5", "mode2 tx_int gated", irq, 0);
    write_tx(8'h11, 1'b1);
    tx_capture(9, b, s, d, irq, c0);
    chk("R5", "mode2 tx_int ninth 1", irq, 1);
    chk("R4", "mode2 frame", b, 9'h111);
  endtask

  task automatic t_tx_b2b;
    logic [8:0] ba, bb; logic s, irq; int d, ca, cb;
    mode = 2'd1; par_en = 1'b0;
    write_tx(8'h81, 1'b0);
    fork
      begin repeat (40) @(negedge clk); write_tx(8'h7E, 1'b0); end
      begin
        tx_capture(8, ba, s, d, irq, ca);
        tx_capture(8, bb, s, d, irq, cb);
      end
    join
    chk("R6", "first frame", ba[7:0], 8'h81);
    chk("R6", "held frame", bb[7:0], 8'h7E);
    chk("R6", "start-to-start gap", cb - ca, 160);
  endtask

  task automatic t_rx_mode1;
    int ic, fc;
    mode = 2'd1; par_en = 1'b0;
    rx_send(8, 9'h03C, 1'b1, 1'b1, ic, fc);
    chk("R7", "mode1 rx_data", rx_data, 8'h3C);
    chk("R7", "mode1 rx_bit8", rx_bit8, 0);
    chk("R8", "rx_int seen", ic >= 0, 1);
    chk("R8", "flag one cycle after int", fc - ic, 1);
    chk("R9", "no error", rx_err, 0);
    mode = 2'd3;
    rx_send(9, 9'h1A5, 1'b1, 1'b1, ic, fc);
    chk("R7", "mode3 rx_data", rx_data, 8'hA5);
    chk("R7", "mode3 rx_bit8", rx_bit8, 1);
    chk("R8", "mode3 flag after int", fc - ic, 1);
  endtask

  task automatic t_rx_errors;
    int ic, fc;
    mode = 2'd1; par_en = 1'b1;
    rx_send(8, 9'h093, 1'b1, 1'b1, ic, fc);
    chk("R9", "good parity", rx_err, 0);
    chk("R7", "parity slot kept in data", rx_data, 8'h93);
    rx_send(8, 9'h013, 1'b1, 1'b1, ic, fc);
    chk("R9", "parity mismatch", rx_err, 1);
    rx_send(8, 9'h093, 1'b1, 1'b0, ic, fc);
    chk("R9", "error sticky over good frame", rx_err, 1);
    pulse_clr_rx();
    chk("R9", "error cleared", rx_err, 0);
    par_en = 1'b0;
    rx_send(8, 9'h055, 1'b0, 1'b1, ic, fc);
    chk("R9", "stop bit 0", rx_err, 1);
    chk("R9", "flag on bad stop", fc >= 0, 1);
    pulse_clr_rx();
  endtask

  task automatic t_rx_nine_gate;
    int ic, fc;
    mode = 2'd2; par_en = 1'b0;
    rx_send(9, 9'h044, 1'b1, 1'b1, ic, fc);
    chk("R8", "mode2 ninth 0 no int", ic, -1);
    chk("R8", "mode2 ninth 0 flag", fc >= 0, 1);
    chk("R7", "mode2 data", rx_data, 8'h44);
    rx_send(9, 9'h144, 1'b1, 1'b1, ic, fc);
    chk("R8", "mode2 ninth 1 int", ic >= 0, 1);
    chk("R7", "mode2 bit8", rx_bit8, 1);
  endtask

  task automatic t_rx_glitch;
    int ic, fc;
    bit seen = 1'b0;
    mode = 2'd1; par_en = 1'b0;
    pulse_clr_rx();
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (rx_int === 1'b1 || rx_flag === 1'b1) seen = 1'b1;
    end
    chk("R10", "glitch ignored", seen, 0);
    rx_send(8, 9'h00F, 1'b1, 1'b1, ic, fc);
    chk("R10", "frame after glitch", rx_data, 8'h0F);
  endtask

  task automatic t_rx_enable;
    int ic, fc;
    mode = 2'd1; par_en = 1'b0;
    rx_en = 1'b0;
    rx_send(8, 9'h066, 1'b1, 1'b1, ic, fc);
    chk("R11", "disabled flag", fc, -1);
    chk("R11", "disabled int", ic, -1);
    rx_en = 1'b1;
    fork
      rx_send(8, 9'h099, 1'b1, 1'b1, ic, fc);
      begin repeat (60) @(negedge clk); rx_en = 1'b0; end
    join
    chk("R11", "abort flag", fc, -1);
    chk("R11", "abort int", ic, -1);
    rx_en = 1'b1;
    rx_send(8, 9'h05A, 1'b1, 1'b1, ic, fc);
    chk("R11", "receive after re-enable", rx_data, 8'h5A);
  endtask

  task automatic t_flags_hold;
    logic [8:0] b; logic s, irq; int d, c0, ic, fc;
    mode = 2'd1; par_en = 1'b0;
    write_tx(8'hC3, 1'b0);
    tx_capture(8, b, s, d, irq, c0);
    repeat (100) @(negedge clk);
    chk("R12", "tx_flag held", tx_flag, 1);
    @(negedge clk); clr_tx = 1'b1;
    @(negedge clk); clr_tx = 1'b0;
    chk("R12", "tx_flag cleared", tx_flag, 0);
    rx_send(8, 9'h0C3, 1'b1, 1'b1, ic, fc);
    repeat (100) @(negedge clk);
    chk("R12", "rx_flag held", rx_flag, 1);
    pulse_clr_rx();
    chk("R12", "rx_flag cleared", rx_flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; os_tick = 1'b1; mode = 2'd1; par_en = 1'b0; rx_en = 1'b1;
    tx_wr = 1'b0; tx_data = '0; tx_bit8 = 1'b0; clr_tx = 1'b0; clr_rx = 1'b0;
    rxd = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_tx_mode1();
    t_tx_parity();
    t_tx_nine();
    t_tx_gate();
    t_tx_b2b();
    t_rx_mode1();
    t_rx_errors();
    t_rx_nine_gate();
    t_rx_glitch();
    t_rx_enable();
    t_flags_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule